// File: doc/BRIEF.md
# Parallel display bus cycle generator

This block runs single transfers on an 8080-style parallel bus that connects to an external display controller. A host asks for one transfer at a time: a command write, a data or parameter write, or a single read. The block then drives active-low chip-select, write-enable and read-enable strobes, a command/data select line and an 8- or 16-bit data bus with its output enable. For a read it returns the captured word to the host.

All edge positions inside a transfer are programmable in ticks. A tick is one or two input clocks. Each strobe has its own assert and deassert tick. Writes and reads have separate cycle lengths. A recovery gap holds chip-select high between transfers, and reads have their own sample point. All settings are copied when a request is accepted, so the host may change them while a transfer is running.

Top module: `pbus_cycle_gen`

## Requirements
- R1: With `tick_div2_i` = 0 a tick lasts one clock. With `tick_div2_i` = 1 a tick lasts two clocks. Every timing value counts in ticks.
- R2: A tick counter starts at 0 in the tick after acceptance. A strobe is low while the counter is at or above its assert tick and below its deassert tick. The strobe outputs are registered, so each one reflects the counter one clock later.
- R3: Chip-select is used on every transfer. Write-enable is used only on writes and read-enable only on reads. `req_kind_i` encoding: 2'b00 is a command write, 2'b01 is a data write, and 2'b10 or 2'b11 is a read.
- R4: `busy_o` rises on the clock that accepts a request, which happens only when `req_valid_i` is high and `busy_o` is low. It stays high for D*(cycle length + gap) clocks, where D is 1 or 2. A request made while `busy_o` is high is ignored.
- R5: `dc_o` is 0 for a command write and 1 for a data write or a read. It holds its level for the whole transfer.
- R6: During a write, `db_oe_o` is high from the chip-select assert tick until the write cycle length is reached, and `db_o` carries the write word. During a read, `db_oe_o` stays low.
- R7: During a read, `db_i` is sampled in the last clock of the tick in which the counter equals the access time. At that point `rd_valid_o` pulses for one clock and `rd_data_o` takes the sampled value. This happens D*(access+1) clocks after acceptance.
- R8: When `width_mode_i` is 2'b11 the bus is 16 bits wide. Any other value selects 8 bits: `db_o[15:8]` is driven 0 and `rd_data_o[15:8]` returns 0.
- R9: Timing, divider and width inputs are captured at acceptance. Changing them during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_div2_i | input | 1 | 1: tick is two clocks |
| width_mode_i | input | 2 | 2'b11 selects 16-bit, any other value 8-bit |
| cs_on_i | input | 4 | Chip-select assert tick |
| cs_off_i | input | 6 | Chip-select deassert tick |
| we_on_i | input | 4 | Write-enable assert tick |
| we_off_i | input | 6 | Write-enable deassert tick |
| re_on_i | input | 4 | Read-enable assert tick |
| re_off_i | input | 6 | Read-enable deassert tick |
| wr_len_i | input | 6 | Write cycle length in ticks |
| rd_len_i | input | 6 | Read cycle length in ticks |
| gap_i | input | 6 | Chip-select recovery ticks after each cycle |
| access_i | input | 6 | Read sample tick |
| req_valid_i | input | 1 | Transfer request |
| req_kind_i | input | 2 | Transfer kind |
| req_data_i | input | 16 | Write word |
| busy_o | output | 1 | Transfer in progress |
| rd_valid_o | output | 1 | Read word valid, one-clock pulse |
| rd_data_o | output | 16 | Read word |
| cs_no | output | 1 | Chip-select, active low |
| we_no | output | 1 | Write-enable, active low |
| re_no | output | 1 | Read-enable, active low |
| dc_o | output | 1 | 0: command, 1: data |
| db_o | output | 16 | Data bus out |
| db_oe_o | output | 1 | Data bus output enable |
| db_i | input | 16 | Data bus in |

## Verification
Every result has a fixed delay after the accepting edge. Strobe and output-enable levels seen n clocks after acceptance reflect counter value floor((n-1)/D). `busy_o` stays high for exactly D*(length+gap) clocks. The read pulse appears D*(access+1) clocks after acceptance. For each transfer, the bench recomputes these windows from values it saved locally at request time. It compares every output at each falling edge from acceptance until two clocks past the end of the transfer, so a transition one clock early or late is reported.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;
  typedef enum logic [1:0] {
    KIND_CMD  = 2'b00,
    KIND_DATA = 2'b01,
    KIND_READ = 2'b10
  } pbus_kind_e;

  localparam logic [1:0] WIDE_MODE = 2'b11;

  function automatic logic kind_is_read(logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_dc(logic [1:0] k);
    return k != KIND_CMD;
  endfunction
endpackage

// File: rtl/pbus_tick_gen.sv
`timescale 1ns/1ps
module pbus_tick_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic active_i,
  input  logic div2_i,
  output logic tick_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= 1'b0;
    else if (start_i)  ph_q <= 1'b0;
    else if (active_i) ph_q <= ~ph_q;
  end

  // tick closes on the second clock when dividing by two
  assign tick_o = active_i & (~div2_i | ph_q);
endmodule

// File: rtl/pbus_seq.sv
`timescale 1ns/1ps
module pbus_seq #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = total_i - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (tick_i) begin
      if (cnt_q == last_cnt) active_q <= 1'b0;
      else                   cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/pbus_strobe.sv
`timescale 1ns/1ps
module pbus_strobe #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned ON_W  = 4,
  parameter int unsigned OFF_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [ON_W-1:0]  on_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             strobe_no
);
  logic [CNT_W-1:0] on_x, off_x;
  logic             hit;

  assign on_x  = {{(CNT_W-ON_W){1'b0}}, on_i};
  assign off_x = {{(CNT_W-OFF_W){1'b0}}, off_i};
  assign hit   = active_i & en_i & (cnt_i >= on_x) & (cnt_i < off_x);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_no <= 1'b1;
    else         strobe_no <= ~hit;
  end
endmodule

// File: rtl/pbus_cycle_gen.sv
`timescale 1ns/1ps
module pbus_cycle_gen #(
  parameter int unsigned ON_W  = 4,
  parameter int unsigned OFF_W = 6,
  parameter int unsigned DW    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_div2_i,
  input  logic [1:0]       width_mode_i,
  input  logic [ON_W-1:0]  cs_on_i,
  input  logic [OFF_W-1:0] cs_off_i,
  input  logic [ON_W-1:0]  we_on_i,
  input  logic [OFF_W-1:0] we_off_i,
  input  logic [ON_W-1:0]  re_on_i,
  input  logic [OFF_W-1:0] re_off_i,
  input  logic [OFF_W-1:0] wr_len_i,
  input  logic [OFF_W-1:0] rd_len_i,
  input  logic [OFF_W-1:0] gap_i,
  input  logic [OFF_W-1:0] access_i,
  input  logic             req_valid_i,
  input  logic [1:0]       req_kind_i,
  input  logic [DW-1:0]    req_data_i,
  output logic             busy_o,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             cs_no,
  output logic             we_no,
  output logic             re_no,
  output logic             dc_o,
  output logic [DW-1:0]    db_o,
  output logic             db_oe_o,
  input  logic [DW-1:0]    db_i
);
  import pbus_pkg::*;

  localparam int unsigned CNT_W = OFF_W + 1;
  localparam int unsigned NS    = 4;   // cs, we, re, output enable
  localparam int unsigned HW    = DW / 2;

  logic             start, tick, active;
  logic [CNT_W-1:0] cnt, total;

  // settings captured at acceptance
  logic [ON_W-1:0]  cs_on_q, we_on_q, re_on_q;
  logic [OFF_W-1:0] cs_off_q, we_off_q, re_off_q, wr_len_q, rd_len_q, gap_q, access_q;
  logic             div2_q, wide_q, rd_q, dc_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic             rvalid_q;

  assign start = req_valid_i & ~active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_on_q  <= '0; we_on_q  <= '0; re_on_q  <= '0;
      cs_off_q <= '0; we_off_q <= '0; re_off_q <= '0;
      wr_len_q <= '0; rd_len_q <= '0; gap_q    <= '0; access_q <= '0;
      div2_q   <= 1'b0; wide_q <= 1'b0; rd_q <= 1'b0; dc_q <= 1'b0;
      wdata_q  <= '0;
    end else if (start) begin
      cs_on_q  <= cs_on_i;  we_on_q  <= we_on_i;  re_on_q  <= re_on_i;
      cs_off_q <= cs_off_i; we_off_q <= we_off_i; re_off_q <= re_off_i;
      wr_len_q <= wr_len_i; rd_len_q <= rd_len_i; gap_q    <= gap_i;
      access_q <= access_i;
      div2_q   <= tick_div2_i;
      wide_q   <= (width_mode_i == WIDE_MODE);
      rd_q     <= kind_is_read(req_kind_i);
      dc_q     <= kind_dc(req_kind_i);
      wdata_q  <= (width_mode_i == WIDE_MODE) ? req_data_i
                                              : {{(DW-HW){1'b0}}, req_data_i[HW-1:0]};
    end
  end

  assign total = (rd_q ? {1'b0, rd_len_q} : {1'b0, wr_len_q}) + {1'b0, gap_q};

  pbus_tick_gen u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .active_i(active),
    .div2_i  (div2_q),
    .tick_o  (tick)
  );

  pbus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tick_i  (tick),
    .total_i (total),
    .active_o(active),
    .cnt_o   (cnt)
  );

  logic [ON_W-1:0]  on_a  [NS];
  logic [OFF_W-1:0] off_a [NS];
  logic             en_a  [NS];
  logic             str_n [NS];

  assign on_a[0] = cs_on_q; assign off_a[0] = cs_off_q; assign en_a[0] = 1'b1;
  assign on_a[1] = we_on_q; assign off_a[1] = we_off_q; assign en_a[1] = ~rd_q;
  assign on_a[2] = re_on_q; assign off_a[2] = re_off_q; assign en_a[2] = rd_q;
  assign on_a[3] = cs_on_q; assign off_a[3] = wr_len_q; assign en_a[3] = ~rd_q;

  for (genvar g = 0; g < NS; g++) begin : g_strobe
    pbus_strobe #(.CNT_W(CNT_W), .ON_W(ON_W), .OFF_W(OFF_W)) u_str (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .en_i     (en_a[g]),
      .cnt_i    (cnt),
      .on_i     (on_a[g]),
      .off_i    (off_a[g]),
      .strobe_no(str_n[g])
    );
  end

  // read sample point
  logic capture;
  assign capture = tick & rd_q & (cnt == {1'b0, access_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= capture;
      if (capture)
        rdata_q <= wide_q ? db_i : {{(DW-HW){1'b0}}, db_i[HW-1:0]};
    end
  end

  assign busy_o     = active;
  assign rd_valid_o = rvalid_q;
  assign rd_data_o  = rdata_q;
  assign cs_no      = str_n[0];
  assign we_no      = str_n[1];
  assign re_no      = str_n[2];
  assign db_oe_o    = ~str_n[3];
  assign dc_o       = dc_q;
  assign db_o       = db_oe_o ? wdata_q : '0;
endmodule

// File: rtl/pbus_cycle_gen_chk.sv
`timescale 1ns/1ps
module pbus_cycle_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic rd_valid_o,
  input logic cs_no,
  input logic we_no,
  input logic re_no,
  input logic dc_o,
  input logic db_oe_o
);
  // R3: write and read strobes never overlap
  a_r3_no_we_re_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> we_no);

  // R6: bus released whenever read-enable is low
  a_r6_oe_off_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !db_oe_o);

  // R4: all strobes idle one clock after an idle bus
  a_r4_idle_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> (cs_no && we_no && re_no && !db_oe_o));

  // R5: command/data level fixed within a transfer
  a_r5_dc_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(dc_o));

  // R7: read valid is a single-clock pulse
  a_r7_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
endmodule

bind pbus_cycle_gen pbus_cycle_gen_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_o    (busy_o),
  .rd_valid_o(rd_valid_o),
  .cs_no     (cs_no),
  .we_no     (we_no),
  .re_no     (re_no),
  .dc_o      (dc_o),
  .db_oe_o   (db_oe_o)
);

// File: tb/test_pbus_cycle_gen.sv
`timescale 1ns/1ps
module test_pbus_cycle_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_div2 = 1'b0;
  logic [1:0]  width_mode = 2'b11;
  logic [3:0]  cs_on = 4'd1, we_on = 4'd2, re_on = 4'd2;
  logic [5:0]  cs_off = 6'd8, we_off = 6'd6, re_off = 6'd7;
  logic [5:0]  wr_len = 6'd9, rd_len = 6'd10, gap = 6'd0, access = 6'd5;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_data = '0;
  logic [15:0] db_in = '0;
  logic        busy, rd_valid, cs_n, we_n, re_n, dc, db_oe;
  logic [15:0] rd_data, db_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pbus_cycle_gen i_pbus_cycle_gen (
    .clk_i(clk), .rst_ni(rst_ni), .tick_div2_i(tick_div2), .width_mode_i(width_mode),
    .cs_on_i(cs_on), .cs_off_i(cs_off), .we_on_i(we_on), .we_off_i(we_off),
    .re_on_i(re_on), .re_off_i(re_off), .wr_len_i(wr_len), .rd_len_i(rd_len),
    .gap_i(gap), .access_i(access), .req_valid_i(req_valid), .req_kind_i(req_kind),
    .req_data_i(req_data), .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .cs_no(cs_n), .we_no(we_n), .re_no(re_n), .dc_o(dc), .db_o(db_out),
    .db_oe_o(db_oe), .db_i(db_in)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One transfer; all expectations from values saved at request time.
  task automatic run_cycle(input logic [1:0] kind, input logic [15:0] data,
                           input logic [15:0] din, input bit extra_req,
                           input bit perturb, input string req);
    int d   = tick_div2 ? 2 : 1;
    bit rd  = kind[1];
    bit wd  = (width_mode == 2'b11);
    int len = rd ? int'(rd_len) : int'(wr_len);
    int tot = len + int'(gap);
    int c_on = cs_on, c_off = cs_off, w_on = we_on, w_off = we_off;
    int r_on = re_on, r_off = re_off, acc = access, wl = wr_len;
    logic [15:0] exp_w = wd ? data : {8'h00, data[7:0]};
    logic [15:0] exp_r = wd ? din  : {8'h00, din[7:0]};
    int e_cs = 0, e_we = 0, e_re = 0, e_oe = 0, e_db = 0, e_busy = 0, e_dc = 0;
    int rv_cnt = 0, rv_at = -1, rv_data = 0;
    req_kind = kind; req_data = data; db_in = din; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n <= d*tot + 1; n++) begin
      bit live = (n >= 1) && (n - 1 < d*tot);
      int c = (n >= 1) ? (n - 1) / d : 0;
      bit x_cs = live && c >= c_on && c < c_off;
      bit x_we = live && !rd && c >= w_on && c < w_off;
      bit x_re = live && rd && c >= r_on && c < r_off;
      bit x_oe = live && !rd && c >= c_on && c < wl;
      if (n == 2 && extra_req) begin
        req_data = ~data; req_kind = 2'b00; req_valid = 1'b1;
      end
      if (n == 3) req_valid = 1'b0;
      if (n == 1 && perturb) begin
        cs_on = 4'd0; cs_off = 6'd2; we_on = 4'd0; we_off = 6'd1;
        wr_len = 6'd2; tick_div2 = ~tick_div2; width_mode = 2'b00;
      end
      if (cs_n  !== !x_cs) e_cs++;
      if (we_n  !== !x_we) e_we++;
      if (re_n  !== !x_re) e_re++;
      if (db_oe !== x_oe)  e_oe++;
      if (x_oe && db_out !== exp_w) e_db++;
      if (busy  !== (n < d*tot)) e_busy++;
      if (n >= 1 && n < d*tot && dc !== (kind != 2'b00)) e_dc++;
      if (rd_valid === 1'b1) begin rv_cnt++; rv_at = n; rv_data = rd_data; end
      @(negedge clk);
    end
    chk(e_cs == 0, req, "cs window errors", e_cs, 0);
    chk(e_busy == 0, "R4", "busy window errors", e_busy, 0);
    chk(e_dc == 0, "R5", "dc level errors", e_dc, 0);
    if (rd) begin
      chk(e_re == 0 && e_we == 0, "R3", "re/we usage errors", e_re + e_we, 0);
      chk(e_oe == 0, "R6", "oe during read", e_oe, 0);
      chk(rv_cnt == 1 && rv_at == d*(acc + 1), "R7", "rd_valid clock", rv_at, d*(acc + 1));
      chk(rv_data == int'(exp_r), req, "rd_data", rv_data, exp_r);
    end else begin
      chk(e_we == 0 && e_re == 0, "R3", "we/re usage errors", e_we + e_re, 0);
      chk(e_oe == 0, "R6", "oe window errors", e_oe, 0);
      chk(e_db == 0, req, "db_o value errors", e_db, 0);
      chk(rv_cnt == 0, "R7", "rd_valid on write", rv_cnt, 0);
    end
  endtask

  task automatic t_reset;
    chk(cs_n === 1 && we_n === 1 && re_n === 1, "R2", "strobes in reset",
        {cs_n, we_n, re_n}, 3'b111);
    chk(busy === 0 && rd_valid === 0 && db_oe === 0, "R4", "busy/rv/oe in reset",
        {busy, rd_valid, db_oe}, 0);
  endtask

  task automatic set_default;
    tick_div2 = 0; width_mode = 2'b11;
    cs_on = 1; cs_off = 8; we_on = 2; we_off = 6; re_on = 2; re_off = 7;
    wr_len = 9; rd_len = 10; gap = 0; access = 5;
  endtask

  task automatic t_cmd_write;  set_default; run_cycle(2'b00, 16'hBEEF, 16'h0, 0, 0, "R2"); endtask
  task automatic t_data_write_busy_req;
    set_default; cs_on = 0; cs_off = 5; we_on = 1; we_off = 4; wr_len = 6;
    run_cycle(2'b01, 16'h1357, 16'h0, 1, 0, "R4");
  endtask
  task automatic t_read;       set_default; run_cycle(2'b10, 16'h0, 16'hA55A, 0, 0, "R7"); endtask
  task automatic t_div2;
    set_default; tick_div2 = 1;
    run_cycle(2'b01, 16'h2468, 16'h0, 0, 0, "R1");
    run_cycle(2'b11, 16'h0, 16'h5AC3, 0, 0, "R1");
  endtask
  task automatic t_narrow;
    set_default; width_mode = 2'b00;
    run_cycle(2'b01, 16'hA5C3, 16'h0, 0, 0, "R8");
    width_mode = 2'b01;
    run_cycle(2'b10, 16'h0, 16'h1234, 0, 0, "R8");
  endtask
  task automatic t_gap;
    set_default; gap = 4; run_cycle(2'b00, 16'h0F0F, 16'h0, 0, 0, "R4");
    gap = 3; access = 9; run_cycle(2'b10, 16'h0, 16'hFFFF, 0, 0, "R7");
  endtask
  task automatic t_snapshot;
    set_default; run_cycle(2'b01, 16'hC0DE, 16'h0, 0, 1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk);
    t_cmd_write;
    t_data_write_busy_req;
    t_read;
    t_div2;
    t_narrow;
    t_gap;
    t_snapshot;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule